// File: doc/BRIEF.md
# Receive Holding Queue with Break Injection

This block is the small queue that sits between a UART receiver and the host data register. It holds up to four received bytes in arrival order. Ordinary bytes arrive on a valid/data pair. A separate break strobe places a zero byte into the queue and sets a sticky delta-break flag. The queue drives a can-accept level back to the upstream receiver. Ordinary data is taken only while the receiver is enabled and the queue is not full.

The host sees the oldest byte on a combinational read port. It removes that byte by pulsing a pop strobe in the same cycle. A flush command empties the queue at once. It stands for the host's receiver-reset command. The ready and full status levels are registered copies of the fill state. They are recomputed at the same edge as the count. When the queue is already full, a break does not get dropped: it replaces the newest entry with zero.

Top module: `rx_hold_queue`

## Requirements
- R1: The queue holds at most 4 bytes, and `count_o` gives the number held. Bytes leave in the order they were accepted.
- R2: `can_accept_o` equals `rcv_en_i` AND NOT `full_o`. A byte offered on `in_valid_i` while `can_accept_o` is 0 is ignored: the count and the contents do not change.
- R3: After any edge at which a byte is pushed, `rdy_o` reads 1.
- R4: A pulse on `brk_i` sets `brk_flag_o` at the next edge. It also pushes a zero byte whether or not the receiver is enabled. An ordinary byte offered in the same cycle is dropped.
- R5: A break that arrives while the queue is full, with no pop in the same cycle, overwrites the newest entry with 0. The count stays at 4 and `full_o` stays 1.
- R6: `pop_data_o` shows the oldest byte, or 0 when the queue is empty. A pop on an empty queue changes nothing.
- R7: A pop removes the oldest byte and leaves `full_o` at 0. `rdy_o` falls to 0 when the queue becomes empty.
- R8: A pop and a push in the same cycle are applied pop first. The count is then unchanged, and a break on a full queue that is also being popped becomes a normal push, not an overwrite.
- R9: `flush_i` empties the queue at the next edge and clears `rdy_o` and `full_o`. It takes priority over a push or pop in the same cycle and leaves `brk_flag_o` alone.
- R10: `brk_clr_i` clears `brk_flag_o` at the next edge. If `brk_i` is also high in that cycle, the flag is set instead.
- R11: After reset the count is 0, `rdy_o`, `full_o` and `brk_flag_o` are 0, and `pop_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rcv_en_i | input | 1 | Receiver enable level |
| flush_i | input | 1 | Receiver-reset command: empty the queue |
| in_valid_i | input | 1 | Ordinary received byte is offered |
| in_data_i | input | DATA_W | Offered byte |
| brk_i | input | 1 | Break event strobe |
| brk_clr_i | input | 1 | Clear the delta-break flag |
| pop_i | input | 1 | Host read of the data register |
| pop_data_o | output | DATA_W | Oldest byte, or 0 when empty |
| can_accept_o | output | 1 | Upstream may deliver a byte |
| rdy_o | output | 1 | Queue holds at least one byte |
| full_o | output | 1 | Queue holds DEPTH bytes |
| brk_flag_o | output | 1 | Sticky delta-break flag |
| count_o | output | CNT_W | Number of bytes held |

## Verification
A push, pop, break, flush or flag clear that is driven before an edge shows up on `count_o`, `rdy_o`, `full_o` and `brk_flag_o` just after that edge. There is one register stage on each of these outputs. `pop_data_o` and `can_accept_o` follow the registered state and the present enable combinationally, so they change in the same cycle the state does. The bench drives every input at the falling edge and steps a queue model at that same point. One cycle later, at the next falling edge and before it drives anything new, the bench compares all six outputs with the model. No result is therefore read in the cycle in which it is still settling.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Fill level after one cycle: flush wins, otherwise pop first, then push.
  function automatic int rxq_next_count(int cnt, logic flush, logic pop, logic push);
    int n;
    if (flush) begin
      n = 0;
    end else begin
      n = cnt;
      if (pop)  n = n - 1;
      if (push) n = n + 1;
    end
    return n;
  endfunction

  // Slot behind a pointer on a ring of the given depth.
  function automatic int rxq_prev_slot(int ptr, int depth);
    return (ptr + depth - 1) % depth;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DEPTH-1:0][DATA_W-1:0] slots;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
      end else if (wr_en && (wr_idx == PTR_W'(g))) begin
        cell_q <= wr_data;
      end
    end
    assign slots[g] = cell_q;
  end

  assign rd_data = slots[rd_idx];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             pop_req,
  input  logic             brk,
  input  logic             data_acc,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic [CNT_W-1:0] count,
  output logic             rdy,
  output logic             full
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, full_q;

  // Named internal events, used by the assertions below.
  logic do_pop, do_push, do_ovw;

  assign do_pop  = pop_req && (cnt_q != '0) && !flush;
  assign do_ovw  = brk && !flush && full_q && !do_pop;
  assign do_push = !flush && (brk || data_acc) && !do_ovw;

  assign wr_en  = do_push || do_ovw;
  assign wr_idx = do_ovw ? PTR_W'(rxq_prev_slot(int'(wptr_q), DEPTH)) : wptr_q;
  assign rd_idx = rptr_q;

  assign cnt_d = CNT_W'(rxq_next_count(int'(cnt_q), flush, do_pop, do_push));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (flush) begin
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        wptr_q <= wptr_q + PTR_W'(do_push);
        rptr_q <= rptr_q + PTR_W'(do_pop);
      end
      cnt_q  <= cnt_d;
      rdy_q  <= (cnt_d != '0);
      full_q <= (cnt_d == FULL_CNT);
    end
  end

  assign count = cnt_q;
  assign rdy   = rdy_q;
  assign full  = full_q;

  // R1: never more than DEPTH entries
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R3: a push leaves the ready flag up
  a_r3_push_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> rdy_q);

  // R5: overwrite keeps the queue full at the same fill level
  a_r5_ovw_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    do_ovw |=> (full_q && (cnt_q == FULL_CNT)));

  // R6: a pop request on an empty queue changes nothing
  a_r6_empty_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt_q == '0 && !flush && !brk && !data_acc) |=> (cnt_q == '0));

  // R7: a pop without a push leaves full clear
  a_r7_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> !full_q);

  // R8: pop and push together keep the count
  a_r8_pop_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && do_push) |=> $stable(cnt_q));

  // R9: flush empties the queue and drops both flags
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && !rdy_q && !full_q));

endmodule

// File: rtl/rxq_brkflag.sv
module rxq_brkflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R4 / R10: set dominates clear
  a_r4_break_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  a_r10_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rcv_en_i,
  input  logic              flush_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              brk_i,
  input  logic              brk_clr_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              can_accept_o,
  output logic              rdy_o,
  output logic              full_o,
  output logic              brk_flag_o,
  output logic [CNT_W-1:0]  count_o
);

  logic              data_acc;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              rdy, full;
  logic [CNT_W-1:0]  count;

  assign can_accept_o = rcv_en_i && !full;
  assign data_acc     = in_valid_i && can_accept_o && !brk_i;
  assign wr_data      = brk_i ? '0 : in_data_i;

  rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_i),
    .pop_req  (pop_i),
    .brk      (brk_i),
    .data_acc (data_acc),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .rd_idx   (rd_idx),
    .count    (count),
    .rdy      (rdy),
    .full     (full)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  rxq_brkflag u_brk (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (brk_i),
    .clr_i  (brk_clr_i),
    .flag_o (brk_flag_o)
  );

  assign pop_data_o = rdy ? rd_data : '0;
  assign rdy_o      = rdy;
  assign full_o     = full;
  assign count_o    = count;

  // R2: full blocks acceptance
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !can_accept_o);

  // R2: refused data leaves the count alone
  a_r2_refused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !can_accept_o && !brk_i && !pop_i && !flush_i) |=> $stable(count));

  // R6: empty queue reads as zero
  a_r6_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (pop_data_o == '0));

endmodule

// File: tb/rx_hold_queue_tb.sv
module rx_hold_queue_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rcv_en = 1'b0, flush = 1'b0, in_valid = 1'b0, brk = 1'b0, brk_clr = 1'b0, pop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [7:0] pop_data;
  logic       can_accept, rdy, full, brk_flag;
  logic [2:0] count;

  always #5 clk = ~clk;

  rx_hold_queue u_dut (
    .clk(clk), .rst_n(rst_n), .rcv_en_i(rcv_en), .flush_i(flush),
    .in_valid_i(in_valid), .in_data_i(in_data), .brk_i(brk), .brk_clr_i(brk_clr),
    .pop_i(pop), .pop_data_o(pop_data), .can_accept_o(can_accept), .rdy_o(rdy),
    .full_o(full), .brk_flag_o(brk_flag), .count_o(count)
  );

  int         n_vec = 0;
  int         n_bad = 0;
  logic [7:0] mq[$];
  bit         m_flag = 0;
  string      phase = "R11 reset";
  bit         done = 0;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] act=%0d exp=%0d", tag, phase, act, exp);
    end
  endtask

  // Compare every output with the model; sampled at the falling edge.
  task automatic compare_all();
    int n = mq.size();
    chk("R1 count", int'(count), n);
    chk("R3 ready", int'(rdy), int'(n != 0));
    chk("R7 full", int'(full), int'(n == 4));
    chk("R2 can_accept", int'(can_accept), int'(rcv_en && n < 4));
    chk("R6 pop_data", int'(pop_data), (n > 0) ? int'(mq[0]) : 0);
    chk("R4 break_flag", int'(brk_flag), int'(m_flag));
  endtask

  // One cycle: check the state, drive new inputs, advance the model.
  task automatic step(bit e, bit v, logic [7:0] d, bit b, bit p, bit f, bit c);
    int pre;
    @(negedge clk);
    compare_all();
    rcv_en = e; in_valid = v; in_data = d; brk = b; pop = p; flush = f; brk_clr = c;
    pre = mq.size();
    if (f) begin
      mq.delete();
    end else begin
      if (p && pre > 0) void'(mq.pop_front());
      if (b) begin
        if (mq.size() == 4) mq[3] = 8'h00;
        else mq.push_back(8'h00);
      end else if (v && e && pre < 4) begin
        mq.push_back(d);
      end
    end
    if (b) m_flag = 1;
    else if (c) m_flag = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired [%s]", phase);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R11 reset";
    step(0, 0, 8'h00, 0, 0, 0, 0);

    phase = "R1 R3 fill in order";
    step(1, 1, 8'h11, 0, 0, 0, 0);
    step(1, 1, 8'h22, 0, 0, 0, 0);
    step(1, 1, 8'h33, 0, 0, 0, 0);
    step(1, 1, 8'h44, 0, 0, 0, 0);
    phase = "R2 refused when full";
    step(1, 1, 8'h55, 0, 0, 0, 0);
    step(1, 1, 8'h66, 0, 0, 0, 0);
    phase = "R7 pop order and full clear";
    step(1, 0, 8'h00, 0, 1, 0, 0);
    step(1, 0, 8'h00, 0, 1, 0, 0);
    phase = "R2 refused when disabled";
    step(0, 1, 8'h77, 0, 0, 0, 0);
    step(0, 0, 8'h00, 0, 1, 0, 0);
    step(0, 0, 8'h00, 0, 1, 0, 0);
    phase = "R6 pop on empty";
    step(0, 0, 8'h00, 0, 1, 0, 0);
    step(0, 0, 8'h00, 0, 1, 0, 0);

    phase = "R4 break while disabled";
    step(0, 1, 8'h99, 1, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0, 0);
    phase = "R10 clear and set race";
    step(0, 0, 8'h00, 0, 0, 0, 1);
    step(0, 0, 8'h00, 0, 0, 0, 0);
    step(1, 1, 8'h5A, 1, 0, 0, 1);
    step(1, 0, 8'h00, 0, 0, 0, 1);

    phase = "R5 overwrite newest when full";
    step(1, 1, 8'hA1, 0, 0, 0, 0);
    step(1, 1, 8'hA2, 0, 0, 0, 0);
    step(1, 0, 8'h00, 0, 0, 0, 0);
    step(1, 0, 8'h00, 1, 0, 0, 0);
    step(1, 0, 8'h00, 1, 0, 0, 0);
    step(1, 0, 8'h00, 0, 1, 0, 0);

    phase = "R8 pop with push";
    step(1, 1, 8'hB1, 0, 1, 0, 0);
    step(1, 1, 8'hB2, 0, 1, 0, 0);
    step(1, 1, 8'hB3, 0, 0, 0, 0);
    step(1, 0, 8'h00, 1, 1, 0, 0);
    step(1, 1, 8'hB4, 0, 1, 0, 0);
    step(1, 0, 8'h00, 0, 0, 0, 0);

    phase = "R9 flush over push and pop";
    step(1, 1, 8'hC1, 0, 1, 1, 0);
    step(1, 1, 8'hC2, 0, 0, 0, 0);
    step(1, 0, 8'h00, 1, 0, 1, 0);
    step(1, 0, 8'h00, 0, 0, 0, 1);

    phase = "R1 R8 mixed traffic";
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 99);
      step($urandom_range(0, 9) != 0, $urandom_range(0, 1) == 1, 8'($urandom_range(0, 255)),
           r < 8, $urandom_range(0, 9) < 4, r > 96, $urandom_range(0, 19) == 0);
    end
    step(0, 0, 8'h00, 0, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule